// File: doc/BRIEF.md
# Data Link Receive Message FIFO with Overflow Discard

This block buffers the output of a bit-oriented data link deframer for a processor. Each incoming beat carries one byte plus start and end markers. A bad flag on the final beat reports a checker failure or an abort. The bytes of a message become readable only once the message has ended. At that point a status record is queued: its kind (good, error/abort or partial) and its byte count. The processor reads status records and data bytes through two show-ahead pop ports.

The storage holds a fixed number of byte locations. The block's main job is to handle the case where the reader falls behind. If a message still needs room after every location is in use, only that unfinished message is thrown away. A partial record with a byte count of zero is queued in its place. Messages that ended earlier stay intact. A sticky flag reports that the store was filled.

Reception then waits for the next start marker. A new message is taken as soon as at least one location is free.

Top module: `dlrx_msg_fifo`

## Requirements
- R1: After reset no data byte or status record is available and the full-error flag reads 0.
- R2: A message that starts with a start-marked beat and ends with an end-marked beat, with bad = 0, queues one status record of kind 00 (good) whose count equals the number of beats. Its bytes are read back in arrival order. None of its bytes is readable before its end beat.
- R3: A message that ends with bad = 1 queues kind 01 (error/abort) with the count of beats received, and all its bytes stay readable.
- R4: A beat that continues a message while all DEPTH locations are in use discards every byte of that message and queues kind 10 (partial) with count 0. Messages that ended earlier and their records stay readable unchanged, and the remaining beats of the discarded message are dropped.
- R5: The full-error flag becomes 1 within two cycles of all DEPTH locations being in use. It stays 1 until a status pop occurs while the store is not full, and that pop clears it.
- R6: Beats that arrive outside a message without a start marker are ignored.
- R7: A start-marked beat inside an unfinished message silently discards the unfinished bytes and begins a new message with that beat.
- R8: A start-marked beat is taken as a new message whenever at least one location is free. If none is free, that message is discarded with a kind 10, count 0 record.
- R9: While all STAT_DEPTH status slots are occupied, a new message is dropped entirely, leaving neither bytes nor a record.
- R10: A message whose end beat fills the last free location is kept as a normal record with count equal to its length, up to DEPTH.
- R11: A data pop with no readable byte, or a status pop with no record, changes no stored content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A receive beat is present |
| in_data | input | 8 | Received byte |
| in_som | input | 1 | Beat is the first of a message |
| in_eom | input | 1 | Beat is the last of a message |
| in_bad | input | 1 | With in_eom: message failed its check or was aborted |
| rd_pop | input | 1 | Consume the byte on rd_data |
| rd_avail | output | 1 | A committed byte is readable |
| rd_data | output | 8 | Oldest readable byte |
| st_pop | input | 1 | Consume the status record; also clears the full-error flag |
| st_avail | output | 1 | A status record is readable |
| st_kind | output | 2 | Record kind: 00 good, 01 error/abort, 10 partial |
| st_count | output | $clog2(DEPTH+1) | Byte count of the record |
| full_err | output | 1 | Sticky full-error flag |

## Verification
The embedded properties are checked on every cycle. They cover four things:
- No byte is ever written past the last free location.
- No record is pushed into a full status queue.
- Any queued partial record carries a zero count, while good and error records carry a nonzero one.
- The full-error flag both sets on a full store and holds until a status pop.

Only the bench's scenarios can show the following:
- The discarded message's bytes vanish while earlier messages come back byte for byte.
- The tail of a discarded message and stray beats are ignored.
- Reception restarts at the next start marker.
- These hold for every committed backlog and message length in a small configuration.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_GOOD    = 2'b00,
        ST_ERRABT  = 2'b01,
        ST_PARTIAL = 2'b10
    } stat_kind_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_MSG  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic wr;
        logic commit;
        logic rewind;
    } store_op_t;

    function automatic stat_kind_e end_kind(input logic bad);
        return bad ? ST_ERRABT : ST_GOOD;
    endfunction

endpackage

// File: rtl/dlrx_byte_ring.sv
module dlrx_byte_ring
    import dlrx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  store_op_t         op,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CW-1:0]     used,
    output logic [CW-1:0]     readable
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, cptr_q, rptr_q;
    logic [AW-1:0]     base, wptr_n, rptr_n;
    logic [CW-1:0]     used_q, pend_q, pend_base, pend_n, used_n;
    logic              do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        base      = op.rewind ? cptr_q : wptr_q;
        pend_base = op.rewind ? '0 : pend_q;
        wptr_n    = op.wr ? bump(base) : base;
        pend_n    = op.commit ? '0 : pend_base + CW'(op.wr);
        do_pop    = rd_pop && (readable != '0);
        rptr_n    = do_pop ? bump(rptr_q) : rptr_q;
        used_n    = used_q - (op.rewind ? pend_q : '0) + CW'(op.wr) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (op.wr) begin
            mem[base] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            cptr_q <= '0;
            rptr_q <= '0;
            used_q <= '0;
            pend_q <= '0;
        end else begin
            wptr_q <= wptr_n;
            rptr_q <= rptr_n;
            used_q <= used_n;
            pend_q <= pend_n;
            if (op.commit) begin
                cptr_q <= wptr_n;
            end
        end
    end

    assign used     = used_q;
    assign readable = used_q - pend_q;
    assign rd_data  = mem[rptr_q];

    // R4: the controller never writes into a location that is still occupied
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        op.wr |-> ((used_q - (op.rewind ? pend_q : '0)) < CW'(DEPTH)));

    // R2: uncommitted bytes never exceed the total occupancy
    p_pend_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        pend_q <= used_q);

endmodule

// File: rtl/dlrx_stat_queue.sv
module dlrx_stat_queue
    import dlrx_pkg::*;
#(
    parameter int SDEPTH = 16,
    parameter int CW = 7,
    localparam int QW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1,
    localparam int NW = $clog2(SDEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  stat_kind_e push_kind,
    input  logic [CW-1:0] push_cnt,
    input  logic       pop,
    output logic       avail,
    output logic       room,
    output stat_kind_e head_kind,
    output logic [CW-1:0] head_cnt
);

    stat_kind_e    kind_mem [SDEPTH];
    logic [CW-1:0] cnt_mem  [SDEPTH];
    logic [QW-1:0] wptr_q, rptr_q;
    logic [NW-1:0] fill_q;
    logic          do_pop;

    function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
        return (p == QW'(SDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign avail  = (fill_q != '0);
    assign room   = (fill_q < NW'(SDEPTH));
    assign do_pop = pop && avail;

    always_ff @(posedge clk) begin
        if (push) begin
            kind_mem[wptr_q] <= push_kind;
            cnt_mem[wptr_q]  <= push_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= bump(wptr_q);
            end
            if (do_pop) begin
                rptr_q <= bump(rptr_q);
            end
            fill_q <= fill_q + NW'(push) - NW'(do_pop);
        end
    end

    assign head_kind = kind_mem[rptr_q];
    assign head_cnt  = cnt_mem[rptr_q];

    // R9: a record is never pushed into a full queue
    p_no_push_full_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> room);

    // R4: a partial record read out always carries a zero count
    p_partial_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (avail && head_kind == ST_PARTIAL) |-> (head_cnt == '0));

    // R3: good and error records read out always count at least one byte
    p_counted_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (avail && head_kind != ST_PARTIAL) |-> (head_cnt != '0));

endmodule

// File: rtl/dlrx_rx_ctrl.sv
module dlrx_rx_ctrl
    import dlrx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_som,
    input  logic          in_eom,
    input  logic          in_bad,
    input  logic [CW-1:0] used,
    input  logic          stat_room,
    output store_op_t     op,
    output logic          st_push,
    output stat_kind_e    st_kind,
    output logic [CW-1:0] st_cnt
);

    rx_state_e     state_q, state_n;
    logic [CW-1:0] msg_cnt_q, msg_cnt_n;
    logic [CW-1:0] used_after;

    always_comb begin
        op         = '0;
        st_push    = 1'b0;
        st_kind    = ST_GOOD;
        st_cnt     = '0;
        state_n    = state_q;
        msg_cnt_n  = msg_cnt_q;
        used_after = used - ((state_q == RX_MSG) ? msg_cnt_q : '0);

        if (in_valid) begin
            if (in_som) begin
                op.rewind = (state_q == RX_MSG);
                msg_cnt_n = '0;
                state_n   = RX_IDLE;
                if (!stat_room) begin
                    // no slot for a record: drop the whole message
                    state_n = RX_IDLE;
                end else if (used_after < CW'(DEPTH)) begin
                    op.wr     = 1'b1;
                    msg_cnt_n = CW'(1);
                    if (in_eom) begin
                        op.commit = 1'b1;
                        st_push   = 1'b1;
                        st_kind   = end_kind(in_bad);
                        st_cnt    = CW'(1);
                        msg_cnt_n = '0;
                    end else begin
                        state_n = RX_MSG;
                    end
                end else begin
                    st_push = 1'b1;
                    st_kind = ST_PARTIAL;
                end
            end else if (state_q == RX_MSG) begin
                if (used < CW'(DEPTH)) begin
                    op.wr     = 1'b1;
                    msg_cnt_n = msg_cnt_q + 1'b1;
                    if (in_eom) begin
                        op.commit = 1'b1;
                        st_push   = 1'b1;
                        st_kind   = end_kind(in_bad);
                        st_cnt    = msg_cnt_q + 1'b1;
                        msg_cnt_n = '0;
                        state_n   = RX_IDLE;
                    end
                end else begin
                    op.rewind = 1'b1;
                    st_push   = 1'b1;
                    st_kind   = ST_PARTIAL;
                    msg_cnt_n = '0;
                    state_n   = RX_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_IDLE;
            msg_cnt_q <= '0;
        end else begin
            state_q   <= state_n;
            msg_cnt_q <= msg_cnt_n;
        end
    end

    // R9: the slot for an open message's record stays reserved in the queue
    p_slot_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_MSG) |-> stat_room);

    // R6: outside a message nothing is written without a start marker
    p_idle_ignores_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_IDLE && !in_som) |-> !op.wr);

endmodule

// File: rtl/dlrx_msg_fifo.sv
module dlrx_msg_fifo
    import dlrx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int STAT_DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    input  logic                        in_som,
    input  logic                        in_eom,
    input  logic                        in_bad,
    input  logic                        rd_pop,
    output logic                        rd_avail,
    output logic [7:0]                  rd_data,
    input  logic                        st_pop,
    output logic                        st_avail,
    output logic [1:0]                  st_kind,
    output logic [$clog2(DEPTH+1)-1:0]  st_count,
    output logic                        full_err
);

    localparam int CW = $clog2(DEPTH + 1);

    store_op_t     op;
    logic [CW-1:0] used, readable;
    logic          stat_room, push;
    stat_kind_e    push_kind, head_kind;
    logic [CW-1:0] push_cnt;
    logic          full_q, is_full;

    dlrx_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_som    (in_som),
        .in_eom    (in_eom),
        .in_bad    (in_bad),
        .used      (used),
        .stat_room (stat_room),
        .op        (op),
        .st_push   (push),
        .st_kind   (push_kind),
        .st_cnt    (push_cnt)
    );

    dlrx_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_data  (in_data),
        .rd_pop   (rd_pop),
        .rd_data  (rd_data),
        .used     (used),
        .readable (readable)
    );

    dlrx_stat_queue #(.SDEPTH(STAT_DEPTH), .CW(CW)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_kind (push_kind),
        .push_cnt  (push_cnt),
        .pop       (st_pop),
        .avail     (st_avail),
        .room      (stat_room),
        .head_kind (head_kind),
        .head_cnt  (st_count)
    );

    assign is_full = (used == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (is_full) begin
            full_q <= 1'b1;
        end else if (st_pop) begin
            full_q <= 1'b0;
        end
    end

    assign rd_avail = (readable != '0);
    assign st_kind  = head_kind;
    assign full_err = full_q;

    // R5: a full store raises the flag on the next cycle
    p_flag_sets_r5: assert property (@(posedge clk) disable iff (rst)
        is_full |=> full_err);

    // R5: the flag only drops on a status pop
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (full_err && !st_pop) |=> full_err);

endmodule

// File: tb/dlrx_msg_fifo_test.sv
module dlrx_msg_fifo_test;

    localparam int DEPTH = 8;
    localparam int SDEPTH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_som = 1'b0, in_eom = 1'b0, in_bad = 1'b0;
    logic [7:0] in_data = '0;
    logic rd_pop = 1'b0, st_pop = 1'b0;
    logic rd_avail, st_avail, full_err;
    logic [7:0] rd_data;
    logic [1:0] st_kind;
    logic [CW-1:0] st_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dlrx_msg_fifo #(.DEPTH(DEPTH), .STAT_DEPTH(SDEPTH)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_som(in_som),
        .in_eom(in_eom), .in_bad(in_bad),
        .rd_pop(rd_pop), .rd_avail(rd_avail), .rd_data(rd_data),
        .st_pop(st_pop), .st_avail(st_avail), .st_kind(st_kind),
        .st_count(st_count), .full_err(full_err)
    );

    function automatic logic [7:0] pat(input int m, input int i);
        return 8'((m * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic beat(input logic [7:0] d, input bit som, input bit eom, input bit bad);
        in_valid = 1'b1; in_data = d; in_som = som; in_eom = eom; in_bad = bad;
        @(negedge clk);
        in_valid = 1'b0; in_som = 1'b0; in_eom = 1'b0; in_bad = 1'b0;
    endtask

    task automatic send_msg(input int m, input int len, input bit bad);
        for (int i = 0; i < len; i++) begin
            beat(pat(m, i), i == 0, i == len - 1, bad);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_stat(input string req, input int kind, input int cnt);
        chk(req, "st_avail", int'(st_avail), 1);
        chk(req, "st_kind", int'(st_kind), kind);
        chk(req, "st_count", int'(st_count), cnt);
        st_pop = 1'b1;
        @(negedge clk);
        st_pop = 1'b0;
    endtask

    task automatic expect_bytes(input string req, input int m, input int len);
        for (int i = 0; i < len; i++) begin
            chk(req, "rd_avail", int'(rd_avail), 1);
            chk(req, "rd_data", int'(rd_data), int'(pat(m, i)));
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
    endtask

    // R11: pops on an empty store leave it empty
    task automatic expect_empty(input string req);
        chk(req, "rd_avail empty", int'(rd_avail), 0);
        chk(req, "st_avail empty", int'(st_avail), 0);
        rd_pop = 1'b1; st_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0; st_pop = 1'b0;
        chk("R11", "rd_avail after empty pop", int'(rd_avail), 0);
        chk("R11", "st_avail after empty pop", int'(st_avail), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rd_avail", int'(rd_avail), 0);
        chk("R1", "st_avail", int'(st_avail), 0);
        chk("R1", "full_err", int'(full_err), 0);

        // R2 / R3 / R10: every length, good and bad ending
        for (int bad = 0; bad < 2; bad++) begin
            for (int len = 1; len <= DEPTH; len++) begin
                int m = bad * 50 + len;
                string req = bad ? "R3" : (len == DEPTH ? "R10" : "R2");
                for (int i = 0; i < len; i++) begin
                    beat(pat(m, i), i == 0, i == len - 1, bit'(bad));
                    if (i == 0 && len > 1) chk("R2", "rd_avail mid-message", int'(rd_avail), 0);
                end
                idle(1);
                chk("R5", "full_err after fill", int'(full_err), int'(len == DEPTH));
                expect_stat(req, bad, len);
                expect_bytes(req, m, len);
                chk("R5", "full_err sticky", int'(full_err), int'(len == DEPTH));
                expect_empty(req);
                chk("R5", "full_err cleared by status pop", int'(full_err), 0);
            end
        end

        // R4 / R8: overflow with every committed backlog
        for (int k = 0; k < DEPTH; k++) begin
            if (k > 0) send_msg(100 + k, k, 1'b0);
            send_msg(200 + k, DEPTH + 2 - k, 1'b0);
            chk("R4", "earlier bytes readable", int'(rd_avail), int'(k > 0));
            send_msg(300 + k, 1, 1'b0);
            idle(1);
            chk("R5", "full_err after overflow", int'(full_err), 1);
            if (k > 0) begin
                expect_stat("R4", 0, k);
                expect_bytes("R4", 100 + k, k);
            end
            expect_stat("R4", 2, 0);
            expect_stat("R8", 0, 1);
            expect_bytes("R8", 300 + k, 1);
            expect_empty("R4");
            chk("R5", "full_err cleared", int'(full_err), 0);
        end

        // R8: start marker with no free location
        send_msg(400, DEPTH, 1'b0);
        beat(8'h5a, 1'b1, 1'b1, 1'b0);
        beat(8'h5b, 1'b0, 1'b0, 1'b0);
        expect_stat("R10", 0, DEPTH);
        expect_stat("R8", 2, 0);
        expect_bytes("R8", 400, DEPTH);
        expect_empty("R8");

        // R6: stray beats outside a message
        beat(8'h11, 1'b0, 1'b0, 1'b0);
        beat(8'h22, 1'b0, 1'b1, 1'b0);
        beat(8'h33, 1'b0, 1'b1, 1'b1);
        chk("R6", "no data from stray beats", int'(rd_avail), 0);
        chk("R6", "no record from stray beats", int'(st_avail), 0);
        send_msg(500, 2, 1'b0);
        expect_stat("R6", 0, 2);
        expect_bytes("R6", 500, 2);
        expect_empty("R6");

        // R7: restart inside an unfinished message
        beat(8'h44, 1'b1, 1'b0, 1'b0);
        beat(8'h55, 1'b0, 1'b0, 1'b0);
        send_msg(600, 2, 1'b0);
        expect_stat("R7", 0, 2);
        expect_bytes("R7", 600, 2);
        expect_empty("R7");

        // R9: status queue full drops a new message
        for (int j = 0; j < SDEPTH; j++) send_msg(700 + j, 1, 1'b0);
        send_msg(710, 2, 1'b0);
        for (int j = 0; j < SDEPTH; j++) begin
            expect_stat("R9", 0, 1);
            expect_bytes("R9", 700 + j, 1);
        end
        expect_empty("R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule